// File: doc/BRIEF.md
# SPI-Mode Memory Card Data-Phase Engine

This block runs the data phase that follows a command the card has already accepted in SPI mode. A start pulse loads the direction, the byte count and an optional register-read mode. For a read, the engine clocks idle bytes until the card sends its start token. It then passes each payload byte to the host over a valid/ready port and clocks in and drops the card's trailing bytes. For a write, it sends an idle byte and the start token, takes each payload byte from the host, appends three zero placeholder bytes, and polls until the card stops signalling busy.

Chip select and command framing are handled outside the block. The block owns SCK, MOSI and MISO for the length of one transfer. Tokens, trailers and polling use a slow clock divisor. Payload bytes use a fast one. Every wait is bounded by a retry count. A transfer ends with a one-cycle done pulse that carries an error code.

Top module: `spiCardDataEngine`

## Requirements
- R1: After reset and between transfers, SCK is low, MOSI is high, and rdValid, wrReady and done are low.
- R2: A read sends 0xFF while it polls MISO one byte at a time. It skips bytes equal to 0xFF. A byte of 0xFE starts the payload, and a start token on the RETRY-th poll is still accepted.
- R3: When a read sees RETRY consecutive polls of 0xFF, it ends with error code 1 (timeout) after exactly RETRY bytes have been clocked.
- R4: When a read poll returns a byte that is neither 0xFF nor 0xFE, the read ends with error code 2 (I/O error) right after that byte.
- R5: Read payload bytes reach rdData in arrival order. While rdValid is high and rdReady is low, rdData holds its value and SCK stays low.
- R6: After the read payload, three more bytes are clocked with MOSI high and their values are dropped. The read then ends with error code 0. MOSI stays high for the whole read.
- R7: A write sends, in this order: 0xFF, 0xFE, the byteLen payload bytes taken on wrValid && wrReady, then 0x00 three times.
- R8: After its trailer, a write polls with 0xFF until MISO returns 0xFF and then ends with error code 0. After RETRY polls that are not 0xFF, it ends with error code 1.
- R9: During payload bytes, each SCK high half lasts FAST_DIV+1 clock cycles. During every other byte it lasts SLOW_DIV+1 cycles. MOSI changes only while SCK is low.
- R10: With regMode set on a read, the transfer is 16 bytes whatever byteLen says. Received bytes 12..15, 8..11, 4..7 and 0..3 are delivered in that order, which reverses the word order and keeps the byte order inside each word. Delivery happens after the trailer.
- R11: done is a single-cycle pulse. err is 0 (none), 1 (timeout) or 2 (I/O error) and never 3.
- R12: A start pulse while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Loads the transfer parameters when idle |
| isWrite | input | 1 | 1 = write transfer, 0 = read transfer |
| regMode | input | 1 | Read of a 16-byte register with word reversal |
| byteLen | input | LEN_W | Payload byte count, 1..MAX_LEN |
| rdData | output | 8 | Read payload byte |
| rdValid | output | 1 | rdData is valid |
| rdReady | input | 1 | Host accepts rdData |
| wrData | input | 8 | Write payload byte |
| wrValid | input | 1 | wrData is valid |
| wrReady | output | 1 | Engine takes wrData this cycle if wrValid is high |
| done | output | 1 | Transfer-complete pulse |
| err | output | 2 | Error code, valid with done |
| sck | output | 1 | Serial clock to the card |
| mosi | output | 1 | Serial data to the card |
| miso | input | 1 | Serial data from the card |

## Verification
The bench builds the engine with FAST_DIV=1, SLOW_DIV=2 and RETRY=6. The two divisors give different high-half lengths (2 and 3 cycles), so each byte's rate can be told from the captured SCK waveform. The small retry count brings both the read token timeout and the write busy timeout within a few dozen bytes, along with the case of a token arriving on the last allowed poll. MAX_LEN stays at 512 so the length port has its full width, while the lengths driven stay short.

// File: rtl/spiDataPkg.sv
package spiDataPkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_IO      = 2'd2
  } errCode_t;

  // Strobes from control to the byte shifter
  typedef struct packed {
    logic       go;
    logic       fast;
    logic [7:0] txByte;
  } shiftCmd_t;

  localparam logic [7:0] IDLE_BYTE   = 8'hFF;
  localparam logic [7:0] START_TOKEN = 8'hFE;
  localparam logic [7:0] PAD_BYTE    = 8'h00;
  localparam int         REG_BYTES   = 16;
endpackage

// File: rtl/spiByteShifter.sv
module spiByteShifter
  import spiDataPkg::*;
#(
  parameter int FAST_DIV = 48,
  parameter int SLOW_DIV = 144,
  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV,
  localparam int DIV_W   = $clog2(MAX_DIV + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  shiftCmd_t  cmd,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       byteDone,
  output logic [7:0] rxByte
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLim;
  logic [2:0]       bitCnt;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic             fastSel;
  logic             sckR;

  assign halfLim = fastSel ? DIV_W'(FAST_DIV) : DIV_W'(SLOW_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt   <= '0;
      bitCnt   <= '0;
      txSh     <= IDLE_BYTE;
      rxSh     <= '0;
      fastSel  <= 1'b0;
      sckR     <= 1'b0;
      busy     <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (!busy) begin
        if (cmd.go) begin
          busy    <= 1'b1;
          txSh    <= cmd.txByte;
          fastSel <= cmd.fast;
          divCnt  <= '0;
          bitCnt  <= '0;
          sckR    <= 1'b0;
        end
      end else if (divCnt == halfLim) begin
        divCnt <= '0;
        if (!sckR) begin
          sckR <= 1'b1;
          rxSh <= {rxSh[6:0], miso};
        end else begin
          sckR <= 1'b0;
          if (bitCnt == 3'd7) begin
            busy     <= 1'b0;
            byteDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 3'd1;
            txSh   <= {txSh[6:0], 1'b1};
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sck    = sckR;
  assign mosi   = busy ? txSh[7] : 1'b1;
  assign rxByte = rxSh;
endmodule

// File: rtl/spiDataCtrl.sv
module spiDataCtrl
  import spiDataPkg::*;
#(
  parameter int MAX_LEN = 512,
  parameter int RETRY   = 1000,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int TRY_W  = $clog2(RETRY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             isWrite,
  input  logic             regMode,
  input  logic [LEN_W-1:0] byteLen,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  output shiftCmd_t        cmd,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic             done,
  output logic [1:0]       err
);
  typedef enum logic [3:0] {
    S_IDLE, S_RD_POLL, S_RD_DATA, S_RD_HOLD, S_RD_TRAIL, S_RD_EMIT,
    S_WR_PRE, S_WR_TOK, S_WR_DATA, S_WR_TRAIL, S_WR_BUSY
  } state_t;

  state_t           state;
  logic             inFlight;
  logic             regM;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cnt;
  logic [TRY_W-1:0] tries;
  logic [1:0]       trail;
  logic [7:0]       holdByte;
  logic [7:0]       regBuf [REG_BYTES];
  logic             needGo;
  logic             lastByte;

  assign lastByte = (cnt == len - 1'b1);

  always_comb begin
    unique case (state)
      S_RD_POLL, S_RD_DATA, S_RD_TRAIL,
      S_WR_PRE, S_WR_TOK, S_WR_TRAIL, S_WR_BUSY: needGo = 1'b1;
      S_WR_DATA: needGo = wrValid;
      default:   needGo = 1'b0;
    endcase
    cmd.go   = needGo && !inFlight;
    cmd.fast = (state == S_RD_DATA) || (state == S_WR_DATA);
    unique case (state)
      S_WR_TOK:   cmd.txByte = START_TOKEN;
      S_WR_DATA:  cmd.txByte = wrData;
      S_WR_TRAIL: cmd.txByte = PAD_BYTE;
      default:    cmd.txByte = IDLE_BYTE;
    endcase
  end

  assign wrReady = (state == S_WR_DATA) && !inFlight;
  assign rdValid = (state == S_RD_HOLD) || (state == S_RD_EMIT);
  assign rdData  = (state == S_RD_EMIT) ? regBuf[{~cnt[3:2], cnt[1:0]}] : holdByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      inFlight <= 1'b0;
      regM     <= 1'b0;
      len      <= '0;
      cnt      <= '0;
      tries    <= '0;
      trail    <= '0;
      holdByte <= '0;
      done     <= 1'b0;
      err      <= ERR_NONE;
      for (int i = 0; i < REG_BYTES; i++) regBuf[i] <= '0;
    end else begin
      done <= 1'b0;
      if (byteDone)    inFlight <= 1'b0;
      else if (cmd.go) inFlight <= 1'b1;

      unique case (state)
        S_IDLE: if (start) begin
          regM  <= regMode && !isWrite;
          len   <= (regMode && !isWrite) ? LEN_W'(REG_BYTES) : byteLen;
          cnt   <= '0;
          tries <= '0;
          trail <= '0;
          state <= isWrite ? S_WR_PRE : S_RD_POLL;
        end
        S_RD_POLL: if (byteDone) begin
          if (rxByte == IDLE_BYTE) begin
            if (tries == TRY_W'(RETRY - 1)) begin
              state <= S_IDLE; done <= 1'b1; err <= ERR_TIMEOUT;
            end else tries <= tries + 1'b1;
          end else if (rxByte == START_TOKEN) begin
            state <= S_RD_DATA;
          end else begin
            state <= S_IDLE; done <= 1'b1; err <= ERR_IO;
          end
        end
        S_RD_DATA: if (byteDone) begin
          if (regM) begin
            regBuf[cnt[3:0]] <= rxByte;
            cnt <= cnt + 1'b1;
            if (lastByte) state <= S_RD_TRAIL;
          end else begin
            holdByte <= rxByte;
            state    <= S_RD_HOLD;
          end
        end
        S_RD_HOLD: if (rdReady) begin
          cnt   <= cnt + 1'b1;
          state <= lastByte ? S_RD_TRAIL : S_RD_DATA;
        end
        S_RD_TRAIL: if (byteDone) begin
          if (trail == 2'd2) begin
            if (regM) begin
              cnt <= '0; state <= S_RD_EMIT;
            end else begin
              state <= S_IDLE; done <= 1'b1; err <= ERR_NONE;
            end
          end else trail <= trail + 2'd1;
        end
        S_RD_EMIT: if (rdReady) begin
          cnt <= cnt + 1'b1;
          if (cnt == LEN_W'(REG_BYTES - 1)) begin
            state <= S_IDLE; done <= 1'b1; err <= ERR_NONE;
          end
        end
        S_WR_PRE: if (byteDone) state <= S_WR_TOK;
        S_WR_TOK: if (byteDone) state <= S_WR_DATA;
        S_WR_DATA: if (byteDone) begin
          cnt <= cnt + 1'b1;
          if (lastByte) state <= S_WR_TRAIL;
        end
        S_WR_TRAIL: if (byteDone) begin
          if (trail == 2'd2) state <= S_WR_BUSY;
          else trail <= trail + 2'd1;
        end
        S_WR_BUSY: if (byteDone) begin
          if (rxByte == IDLE_BYTE) begin
            state <= S_IDLE; done <= 1'b1; err <= ERR_NONE;
          end else if (tries == TRY_W'(RETRY - 1)) begin
            state <= S_IDLE; done <= 1'b1; err <= ERR_TIMEOUT;
          end else tries <= tries + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  hold_rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid && !rdReady |=> rdValid && $stable(rdData));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err != 2'd3);
  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && (state != S_IDLE) |=> (state != S_IDLE) || done);
endmodule

// File: rtl/spiCardDataEngine.sv
module spiCardDataEngine
  import spiDataPkg::*;
#(
  parameter int FAST_DIV = 48,
  parameter int SLOW_DIV = 144,
  parameter int RETRY    = 1000,
  parameter int MAX_LEN  = 512,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             isWrite,
  input  logic             regMode,
  input  logic [LEN_W-1:0] byteLen,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic             done,
  output logic [1:0]       err,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  shiftCmd_t  cmd;
  logic       shBusy;
  logic       byteDone;
  logic [7:0] rxByte;

  spiDataCtrl #(.MAX_LEN(MAX_LEN), .RETRY(RETRY)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .isWrite(isWrite),
    .regMode(regMode), .byteLen(byteLen), .byteDone(byteDone),
    .rxByte(rxByte), .cmd(cmd), .rdData(rdData), .rdValid(rdValid),
    .rdReady(rdReady), .wrData(wrData), .wrValid(wrValid),
    .wrReady(wrReady), .done(done), .err(err)
  );

  spiByteShifter #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) shift_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .miso(miso), .sck(sck),
    .mosi(mosi), .busy(shBusy), .byteDone(byteDone), .rxByte(rxByte)
  );

  // R5
  stall_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> !sck);
  // R1
  idle_mosi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shBusy |-> mosi && !sck);
endmodule

// File: tb/spiCardDataEngine_tb_top.sv
module spiCardDataEngine_tb_top;
  localparam int FAST = 1, SLOW = 2, RETRY = 6, MAXL = 512;
  localparam int LW = $clog2(MAXL + 1);

  logic clk = 0, rst_n = 0;
  logic start = 0, isWrite = 0, regMode = 0, rdReady = 0, wrValid = 0;
  logic [LW-1:0] byteLen = '0;
  logic [7:0] wrData = '0, rdData;
  logic rdValid, wrReady, done, sck, mosi, miso;
  logic [1:0] err;

  int checks = 0, errors = 0;
  always #4 clk = ~clk;

  spiCardDataEngine #(.FAST_DIV(FAST), .SLOW_DIV(SLOW), .RETRY(RETRY), .MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .isWrite(isWrite), .regMode(regMode),
    .byteLen(byteLen), .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady), .done(done), .err(err),
    .sck(sck), .mosi(mosi), .miso(miso));

  // Card model: shifts scripted bytes out MSB first, logs MOSI bytes
  logic [7:0] cardQ[$];
  logic [7:0] cardByte = 8'hFF;
  logic [2:0] cardBit = 0;
  logic [7:0] mosiSh = 0;
  int mosiBits = 0;
  logic [7:0] mosiLog[$];
  assign miso = cardByte[~cardBit];

  always @(posedge sck) begin
    mosiSh = {mosiSh[6:0], mosi};
    mosiBits++;
    if (mosiBits == 8) begin mosiLog.push_back(mosiSh); mosiBits = 0; end
    if (cardBit == 3'd7) begin
      cardBit = 0;
      cardByte = (cardQ.size() > 0) ? cardQ.pop_front() : 8'hFF;
    end else cardBit++;
  end

  // SCK high-half length of the last bit of each byte
  int hiRun = 0, hiBits = 0;
  int hiQ[$];
  logic mosiBad = 0;
  logic prevSck = 0, prevMosi = 1;
  always @(negedge clk) begin
    if (sck && prevSck && mosi != prevMosi) mosiBad = 1;
    prevSck = sck; prevMosi = mosi;
    if (sck) hiRun++;
    else if (hiRun != 0) begin
      hiBits++;
      if (hiBits == 8) begin hiQ.push_back(hiRun); hiBits = 0; end
      hiRun = 0;
    end
  end

  logic [7:0] payQ[$], gotQ[$], expMosi[$], expGot[$];
  bit expFast[$];
  logic [1:0] lastErr;
  bit stallReq = 0, injectStart = 0, hung = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic loadCard();
    cardByte = (cardQ.size() > 0) ? cardQ.pop_front() : 8'hFF;
    cardBit = 0;
  endtask

  task automatic runXfer(input bit wr, input bit rm, input int len);
    int widx = 0, cyc = 0;
    bit fin = 0;
    gotQ.delete(); mosiLog.delete(); hiQ.delete();
    mosiBits = 0; hiBits = 0; mosiBad = 0;
    loadCard();
    @(negedge clk);
    start = 1; isWrite = wr; regMode = rm; byteLen = LW'(len);
    @(negedge clk);
    start = 0; isWrite = 0; regMode = 0; byteLen = '0;
    while (!fin && cyc < 30000) begin
      @(negedge clk); cyc++;
      if (injectStart && cyc == 25) begin start = 1; isWrite = !wr; byteLen = LW'(3); end
      else start = 0;
      if (done) begin fin = 1; lastErr = err; end
      if (rdValid && stallReq) begin
        logic [7:0] v = rdData;
        bit bad = 0;
        rdReady = 0;
        repeat (20) begin @(negedge clk); if (sck || rdData != v || !rdValid) bad = 1; end
        stallReq = 0;
        check(!bad, "R5", "sck low and rdData held during stall", int'(bad), 0);
      end
      if (rdValid && ($urandom % 4 != 0)) begin gotQ.push_back(rdData); rdReady = 1; end
      else rdReady = 0;
      if (wrReady && widx < payQ.size() && ($urandom % 4 != 0)) begin
        wrValid = 1; wrData = payQ[widx]; widx++;
      end else wrValid = 0;
    end
    rdReady = 0; wrValid = 0; injectStart = 0;
    if (!fin) begin hung = 1; check(0, "R11", "transfer never signalled done", 0, 1); end
    @(negedge clk);
    check(!done, "R11", "done single pulse", int'(done), 0);
  endtask

  task automatic compareRun(input string req, input int expErr);
    int bad = 0;
    check(lastErr == 2'(expErr), req, "error code", int'(lastErr), expErr);
    check(mosiLog.size() == expMosi.size(), req, "bytes clocked", mosiLog.size(), expMosi.size());
    foreach (expMosi[i]) if (i < mosiLog.size() && mosiLog[i] != expMosi[i]) bad++;
    check(bad == 0, req, "MOSI byte mismatches", bad, 0);
    bad = 0;
    check(gotQ.size() == expGot.size(), req, "read bytes delivered", gotQ.size(), expGot.size());
    foreach (expGot[i]) if (i < gotQ.size() && gotQ[i] != expGot[i]) bad++;
    check(bad == 0, req, "read data mismatches", bad, 0);
    bad = 0;
    foreach (expFast[i])
      if (i < hiQ.size() && hiQ[i] != (expFast[i] ? FAST + 1 : SLOW + 1)) bad++;
    check(bad == 0 && hiQ.size() == expFast.size(), "R9", "SCK half-period mismatches", bad, 0);
    check(!mosiBad, "R9", "MOSI changed while SCK high", int'(mosiBad), 0);
    check(!sck && mosi && !rdValid && !wrReady, "R1", "idle outputs after transfer",
          int'({sck, mosi, rdValid, wrReady}), 4);
  endtask

  function automatic void pushExp(input int n, input logic [7:0] b, input bit f);
    for (int i = 0; i < n; i++) begin expMosi.push_back(b); expFast.push_back(f); end
  endfunction

  // Read: polls FF bytes, then either token / bad byte / nothing
  task automatic doRead(input int polls, input int kind, input int len, input bit rm, input string req);
    int n = rm ? 16 : len;
    cardQ.delete(); expMosi.delete(); expFast.delete(); expGot.delete(); payQ.delete();
    for (int i = 0; i < polls; i++) cardQ.push_back(8'hFF);
    if (kind == 0) begin
      cardQ.push_back(8'hFE);
      for (int i = 0; i < n; i++) payQ.push_back(8'($urandom));
      foreach (payQ[i]) cardQ.push_back(payQ[i]);
      for (int i = 0; i < 3; i++) cardQ.push_back(8'($urandom));
      pushExp(polls + 1, 8'hFF, 0); pushExp(n, 8'hFF, 1); pushExp(3, 8'hFF, 0);
      for (int k = 0; k < n; k++) expGot.push_back(rm ? payQ[(3 - k / 4) * 4 + k % 4] : payQ[k]);
      runXfer(0, rm, len);
      compareRun(req, 0);
    end else if (kind == 1) begin
      pushExp(RETRY, 8'hFF, 0);
      runXfer(0, rm, len);
      compareRun("R3", 1);
    end else begin
      cardQ.push_back(8'h3C);
      pushExp(polls + 1, 8'hFF, 0);
      runXfer(0, rm, len);
      compareRun("R4", 2);
    end
  endtask

  task automatic doWrite(input int len, input int busyN, input string req);
    int polls = (busyN >= RETRY) ? RETRY : busyN + 1;
    cardQ.delete(); expMosi.delete(); expFast.delete(); expGot.delete(); payQ.delete();
    for (int i = 0; i < len; i++) payQ.push_back(8'($urandom));
    for (int i = 0; i < len + 5; i++) cardQ.push_back(8'($urandom));
    for (int i = 0; i < busyN; i++) cardQ.push_back(8'h00);
    cardQ.push_back(8'hFF);
    pushExp(1, 8'hFF, 0); pushExp(1, 8'hFE, 0);
    foreach (payQ[i]) begin expMosi.push_back(payQ[i]); expFast.push_back(1); end
    pushExp(3, 8'h00, 0); pushExp(polls, 8'hFF, 0);
    runXfer(1, 0, len);
    compareRun(req, (busyN >= RETRY) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    check(!sck && mosi && !done && !rdValid && !wrReady, "R1", "reset outputs",
          int'({sck, mosi, done, rdValid, wrReady}), 8);
    rst_n = 1;
    repeat (2) @(negedge clk);

    doRead(2, 0, 5, 0, "R2");              // token after 2 idle polls
    doRead(RETRY - 1, 0, 3, 0, "R2");      // token on the last allowed poll
    doRead(RETRY + 2, 1, 4, 0, "R3");      // no token: timeout
    doRead(1, 2, 4, 0, "R4");              // bad token byte
    stallReq = 1;
    doRead(0, 0, 8, 0, "R5");              // host backpressure stall
    doRead(1, 0, 1, 0, "R6");              // single byte, trailer then done
    doRead(0, 0, 7, 1, "R10");             // register mode, byteLen ignored
    doWrite(6, 3, "R7");                   // write with busy period
    doWrite(1, 0, "R8");                   // not busy at all
    doWrite(2, RETRY + 3, "R8");           // busy forever: timeout
    injectStart = 1;
    doRead(1, 0, 6, 0, "R12");             // start mid-transfer ignored
    injectStart = 1;
    doWrite(4, 1, "R12");

    for (int it = 0; it < 10 && !hung; it++) begin
      int sel = $urandom % 3;
      if (sel == 0) doRead($urandom % RETRY, 0, 1 + $urandom % 30, 0, "R2");
      else if (sel == 1) doWrite(1 + $urandom % 30, $urandom % (RETRY - 1), "R7");
      else doRead($urandom % 3, 0, 1 + $urandom % 20, 1, "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule